// File: doc/BRIEF.md
# Compare-Match Watchdog Timer

This block counts overflow pulses from an upstream interval timer with a small up-counter and compares the count with a programmed limit. When the count reaches the limit the block signals an event. A mode bit decides what the event does: in timer mode it raises a one-cycle interrupt request and the count wraps on the following tick. In watchdog mode it raises a one-cycle system reset request and the counter restarts at once.

Software reaches the block through a byte-wide write-only port with two addresses. One carries the limit together with a counter-clear bit that acts only in the cycle of the write and is never stored. The other is a shared clock control byte, and only the mode bit in it belongs to this block. The interval timer itself is outside the block and appears only as the `tick` input.

Top module: `cmp_wdog`

## Requirements
- R1: After reset the counter is 0, the limit is 63 (all ones), timer mode is selected and `irq` and `wdt_rst` are low. With no writes, the first `irq` follows the 63rd tick.
- R2: The counter changes only in cycles where `tick` is high or a clear is written. In all other cycles the count, and therefore the event timing, is held.
- R3: On a tick the next count is 0 if the count already equals the limit, and count+1 otherwise. An event is raised when this next count equals the limit. Outputs are registered, so they are high in the cycle after the tick.
- R4: In timer mode (mode bit 0) an event drives `irq` high for one cycle while `wdt_rst` stays low. With limit L and ticks from a count of 0, events repeat every L+1 ticks.
- R5: In watchdog mode (mode bit 1) an event drives `wdt_rst` high for one cycle while `irq` stays low, and the counter becomes 0 in the same edge. Events repeat every L ticks, or on every tick when L is 0.
- R6: A write to address 0xE0 loads the limit from data bits 5..0. If data bit 6 is 1, the counter is cleared at that edge. Bit 6 is not stored, so a write with bit 6 at 0 leaves the count running.
- R7: A write to address 0xD3 sets the mode from data bit 5. All other bits of that byte are ignored, and writes to any other address change nothing.
- R8: When a clear and a tick fall in the same cycle, the clear wins: the counter becomes 0 and no event is raised.
- R9: A tick in the same cycle as a limit or mode write is judged against the old limit and mode. The new values apply from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle overflow pulse from the interval timer |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 8 | Register write data |
| irq | output | 1 | Timer-mode match interrupt request, one-cycle pulse |
| wdt_rst | output | 1 | Watchdog-mode system reset request, one-cycle pulse |

## Verification
A wrong count, limit or mode stays hidden until the next event. It then shows at the ports as an `irq` or `wdt_rst` pulse one or more ticks early or late, or on the wrong output. The bench sweeps every limit value in both modes and compares both outputs in every cycle, so a fault appears at the latest one full period (up to 64 ticks) after it arises. Clears, ignored writes and tick collisions are each followed by ticks until an event occurs, so their effect on the hidden count is exposed.

// File: rtl/cmp_wdog_pkg.sv
package cmp_wdog_pkg;

    typedef enum logic {
        MODE_TIMER = 1'b0,
        MODE_WDOG  = 1'b1
    } wd_mode_e;

endpackage

// File: rtl/cmp_wdog_regs.sv
module cmp_wdog_regs
    import cmp_wdog_pkg::*;
#(
    parameter int CNT_W  = 6,
    parameter int DATA_W = 8,
    parameter int ADDR_W = 8,
    parameter logic [ADDR_W-1:0] LIM_ADDR = 8'hE0,
    parameter logic [ADDR_W-1:0] CTL_ADDR = 8'hD3,
    parameter int MODE_BIT = 5,
    parameter int CLR_BIT  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [CNT_W-1:0]  limit,
    output wd_mode_e          mode,
    output logic              clr
);

    typedef struct packed {
        logic [CNT_W-1:0] limit;
        wd_mode_e         mode;
    } regs_t;

    localparam regs_t REGS_RST = '{limit: '1, mode: MODE_TIMER};

    regs_t regs_d, regs_q;
    logic  lim_wr, ctl_wr;
    logic  unused_data;

    assign unused_data = ^wr_data;

    always_comb begin
        regs_d = regs_q;
        lim_wr = wr_en && (wr_addr == LIM_ADDR);
        ctl_wr = wr_en && (wr_addr == CTL_ADDR);
        if (lim_wr) begin
            regs_d.limit = wr_data[CNT_W-1:0];
        end
        if (ctl_wr) begin
            regs_d.mode = wd_mode_e'(wr_data[MODE_BIT]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= REGS_RST;
        end else begin
            regs_q <= regs_d;
        end
    end

    // clear is a strobe in the write cycle only; nothing is stored
    assign clr   = lim_wr && wr_data[CLR_BIT];
    assign limit = regs_q.limit;
    assign mode  = regs_q.mode;

    // R7: mode only moves on a control write
    a_r7_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && (wr_addr == CTL_ADDR)) |=> $stable(mode));

    // R6: limit only moves on a limit write
    a_r6_limit_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && (wr_addr == LIM_ADDR)) |=> $stable(limit));

endmodule

// File: rtl/cmp_wdog_core.sv
module cmp_wdog_core
    import cmp_wdog_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             clr,
    input  logic [CNT_W-1:0] limit,
    input  wd_mode_e         mode,
    output logic             irq,
    output logic             wdt_rst
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             irq;
        logic             rst;
    } core_t;

    localparam core_t CORE_RST = '{cnt: '0, irq: 1'b0, rst: 1'b0};

    core_t            st_d, st_q;
    logic [CNT_W-1:0] nxt_cnt;
    logic             hit;

    always_comb begin
        st_d     = st_q;
        st_d.irq = 1'b0;
        st_d.rst = 1'b0;
        nxt_cnt  = (st_q.cnt == limit) ? '0 : st_q.cnt + CNT_W'(1);
        hit      = 1'b0;
        if (clr) begin
            st_d.cnt = '0;
        end else if (tick) begin
            hit      = (nxt_cnt == limit);
            st_d.cnt = (hit && (mode == MODE_WDOG)) ? '0 : nxt_cnt;
            st_d.irq = hit && (mode == MODE_TIMER);
            st_d.rst = hit && (mode == MODE_WDOG);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= CORE_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq     = st_q.irq;
    assign wdt_rst = st_q.rst;

    // R2: count holds without tick or clear
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !clr) |=> $stable(st_q.cnt));

    // R8: clear beats a coincident tick
    a_r8_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (st_q.cnt == '0) && !irq && !wdt_rst);

    // R3 / R4: a timer event leaves the count sitting on the old limit
    a_r4_irq_at_limit: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (st_q.cnt == $past(limit)) && $past(tick) && ($past(mode) == MODE_TIMER));

    // R5: a watchdog event restarts the count
    a_r5_wd_restart: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_rst |-> (st_q.cnt == '0) && $past(tick) && ($past(mode) == MODE_WDOG));

    // R4 / R5: never both outputs together
    a_r4_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq && wdt_rst));

endmodule

// File: rtl/cmp_wdog.sv
module cmp_wdog
    import cmp_wdog_pkg::*;
#(
    parameter int CNT_W  = 6,
    parameter int DATA_W = 8,
    parameter int ADDR_W = 8,
    parameter logic [ADDR_W-1:0] LIM_ADDR = 8'hE0,
    parameter logic [ADDR_W-1:0] CTL_ADDR = 8'hD3,
    parameter int MODE_BIT = 5,
    parameter int CLR_BIT  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              irq,
    output logic              wdt_rst
);

    logic [CNT_W-1:0] limit;
    wd_mode_e         mode;
    logic             clr;

    cmp_wdog_regs #(
        .CNT_W    (CNT_W),
        .DATA_W   (DATA_W),
        .ADDR_W   (ADDR_W),
        .LIM_ADDR (LIM_ADDR),
        .CTL_ADDR (CTL_ADDR),
        .MODE_BIT (MODE_BIT),
        .CLR_BIT  (CLR_BIT)
    ) i_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .limit   (limit),
        .mode    (mode),
        .clr     (clr)
    );

    cmp_wdog_core #(
        .CNT_W (CNT_W)
    ) i_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .clr     (clr),
        .limit   (limit),
        .mode    (mode),
        .irq     (irq),
        .wdt_rst (wdt_rst)
    );

endmodule

// File: tb/test_cmp_wdog.sv
module test_cmp_wdog;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_addr = 8'h00;
    logic [7:0] wr_data = 8'h00;
    logic       irq, wdt_rst;

    int n_chk = 0;
    int n_bad = 0;

    // reference state, written from the requirements
    logic [5:0] m_cnt = 6'd0;
    logic [5:0] m_lim = 6'h3F;
    logic       m_mode = 1'b0;

    always #10 clk = ~clk;

    cmp_wdog i_cmp_wdog (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .irq     (irq),
        .wdt_rst (wdt_rst)
    );

    task automatic check(input logic got_i, got_r, exp_i, exp_r, input string tag);
        n_chk++;
        if (got_i !== exp_i || got_r !== exp_r) begin
            n_bad++;
            $display("FAIL %s irq,wdt_rst got %b,%b expected %b,%b", tag, got_i, got_r, exp_i, exp_r);
        end
    endtask

    // one cycle: drive at negedge, model the edge, check at next negedge
    task automatic cyc(input logic t, we, input logic [7:0] a, d, input string tag);
        logic       clr_w, hit, e_i, e_r;
        logic [5:0] nxt, lim_n;
        logic       mode_n;
        tick = t; wr_en = we; wr_addr = a; wr_data = d;
        clr_w  = we && (a == 8'hE0) && d[6];
        lim_n  = (we && a == 8'hE0) ? d[5:0] : m_lim;
        mode_n = (we && a == 8'hD3) ? d[5] : m_mode;
        hit = 1'b0;
        if (clr_w) begin
            m_cnt = 6'd0;
        end else if (t) begin
            nxt = (m_cnt == m_lim) ? 6'd0 : m_cnt + 6'd1;
            hit = (nxt == m_lim);
            m_cnt = (hit && m_mode) ? 6'd0 : nxt;
        end
        e_i = hit && !m_mode;
        e_r = hit && m_mode;
        m_lim = lim_n;
        m_mode = mode_n;
        @(negedge clk);
        check(irq, wdt_rst, e_i, e_r, tag);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        check(irq, wdt_rst, 1'b0, 1'b0, "R1 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check(irq, wdt_rst, 1'b0, 1'b0, "R1 after reset");

        // R1: default limit 63, first irq after 63rd tick
        for (int k = 0; k < 70; k++) cyc(1'b1, 1'b0, 8'h00, 8'h00, "R1 default limit");

        // R3 R4: timer-mode sweep over every limit, odd limits with idle gaps (R2)
        for (int lim = 0; lim < 64; lim++) begin
            cyc(1'b0, 1'b1, 8'hE0, 8'h40 | 8'(lim), "R6 load+clear");
            for (int k = 0; k < 2 * lim + 4; k++) begin
                cyc(1'b1, 1'b0, 8'h00, 8'h00, "R4 timer sweep");
                if (lim % 2 == 1) cyc(1'b0, 1'b0, 8'h00, 8'h00, "R2 idle hold");
            end
        end

        // R7: enter watchdog mode with noise in the other control bits
        cyc(1'b0, 1'b1, 8'hD3, 8'hDF, "R7 mode set");
        // R5: watchdog sweep
        for (int lim = 0; lim < 64; lim++) begin
            cyc(1'b0, 1'b1, 8'hE0, 8'h40 | 8'(lim), "R6 load+clear");
            for (int k = 0; k < 2 * lim + 4; k++) begin
                cyc(1'b1, 1'b0, 8'h00, 8'h00, "R5 watchdog sweep");
                if (lim % 3 == 2) cyc(1'b0, 1'b0, 8'h00, 8'h00, "R2 idle hold");
            end
        end

        // R8: clear with tick just before a match
        cyc(1'b0, 1'b1, 8'hE0, 8'h45, "R6 load 5");
        for (int k = 0; k < 4; k++) cyc(1'b1, 1'b0, 8'h00, 8'h00, "R8 approach");
        cyc(1'b1, 1'b1, 8'hE0, 8'h45, "R8 clear+tick");
        for (int k = 0; k < 12; k++) cyc(1'b1, 1'b0, 8'h00, 8'h00, "R8 after clear");

        // R6: limit write without clear keeps counting
        for (int k = 0; k < 2; k++) cyc(1'b1, 1'b0, 8'h00, 8'h00, "R6 pre");
        cyc(1'b0, 1'b1, 8'hE0, 8'h09, "R6 no clear");
        for (int k = 0; k < 20; k++) cyc(1'b1, 1'b0, 8'h00, 8'h00, "R6 keep count");

        // R7: writes elsewhere and other control bits ignored
        cyc(1'b1, 1'b1, 8'hE1, 8'h42, "R7 other addr");
        cyc(1'b1, 1'b1, 8'h60, 8'hFF, "R7 other addr");
        cyc(1'b1, 1'b1, 8'hD3, 8'hFF, "R7 ctl noise");
        for (int k = 0; k < 20; k++) cyc(1'b1, 1'b0, 8'h00, 8'h00, "R7 unchanged");

        // R9: writes coinciding with ticks use old settings
        cyc(1'b0, 1'b1, 8'hE0, 8'h43, "R9 setup");
        cyc(1'b1, 1'b0, 8'h00, 8'h00, "R9 tick");
        cyc(1'b1, 1'b0, 8'h00, 8'h00, "R9 tick");
        cyc(1'b1, 1'b1, 8'hE0, 8'h07, "R9 limit write on match tick");
        for (int k = 0; k < 10; k++) cyc(1'b1, 1'b0, 8'h00, 8'h00, "R9 new limit");
        cyc(1'b1, 1'b1, 8'hD3, 8'h00, "R9 mode write with tick");
        for (int k = 0; k < 20; k++) cyc(1'b1, 1'b0, 8'h00, 8'h00, "R4 back to timer");

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired, all requirements, got hang expected finish");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule